// File: doc/BRIEF.md
# Parking Bus Arbiter with Turnaround Gap

This block decides which of five initiators owns a shared PCI-style bus: one on-chip controller and four off-chip masters. The four off-chip masters request the bus on active-low request lines and receive active-low grant lines. The on-chip controller uses a plain active-high request and grant pair. When nobody asks for the bus, the grant rests on the on-chip controller. That controller then keeps the address, parity and command drivers enabled, so the lines never float. When ownership moves from one initiator to another, the arbiter inserts one clock in which no grant is given. This lets the previous driver release the lines before the next one starts its address phase.

A mode input switches the block between host operation, where the arbitration described above is active, and device operation. In device operation an off-chip arbiter decides ownership. Lane 0 of the off-chip pins is then reused: its grant output carries the on-chip controller's request outward, and its request input carries the off-chip arbiter's grant inward. The drive enable then follows the incoming grant, after a one-clock gap. Configuration transfers are refused in device operation.

Top module: `pci_park_arbiter`

## Requirements
- R1: In host mode at most one initiator is granted in any clock (int_gnt high counts as one, each low ext_gnt_n bit counts as one); off-chip grants are active low.
- R2: Out of reset in host mode, and whenever no initiator has requested during a change opportunity, the grant rests on the on-chip controller (int_gnt=1, int_oe=1, ext_gnt_n all ones).
- R3: When the on-chip controller already holds the parked grant and raises int_req, its grant and int_oe stay asserted with no gap clock.
- R4: When the grant moves to a different initiator, the clock after the decision has no grant asserted at all; the new grant appears on the following clock.
- R5: Initiators are numbered 0 (on-chip, int_req) and 1..4 (ext_req_n bit 0..3). A change picks the first requester found scanning upward from the current owner plus one, wrapping modulo 5, with the current owner considered last.
- R6: A new decision is taken only when the bus is idle (frame_n and irdy_n both high) or the current owner's request is inactive; otherwise the grant is held. No decision is taken during a gap clock.
- R7: In host mode int_oe is asserted exactly when int_gnt is, and never while any ext_gnt_n bit is low.
- R8: In device mode ext_gnt_n[0] equals the inverse of int_req (an outgoing active-low request), ext_gnt_n[3:1] stay high, and ext_req_n[3:1] have no effect on any output.
- R9: In device mode ext_req_n[0] is an active-low incoming grant. int_gnt goes high the clock after it is sampled low. int_oe goes high one clock later if the grant is still held. Both drop the clock after it is sampled high.
- R10: cfg_reject equals cfg_req in device mode and is low in host mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host (local arbitration), 0 = device (off-chip arbiter) |
| int_req | input | 1 | On-chip controller bus request, active high |
| cfg_req | input | 1 | On-chip controller asks to issue a configuration transfer |
| frame_n | input | 1 | Bus frame signal, active low |
| irdy_n | input | 1 | Bus initiator-ready signal, active low |
| ext_req_n | input | NUM_EXT | Off-chip requests, active low; bit 0 is the incoming grant in device mode |
| ext_gnt_n | output | NUM_EXT | Off-chip grants, active low; bit 0 is the outgoing request in device mode |
| int_gnt | output | 1 | On-chip controller owns the bus |
| int_oe | output | 1 | Enable for the on-chip address, parity and command drivers |
| cfg_reject | output | 1 | Configuration request refused |

## Verification
The arbiter is driven with an idle bus, with the parked controller starting its own transfer, and with a single off-chip requester. It is also driven with two sparse off-chip requesters and with all five requesting at once. The single requester separates parking and the gap clock from plain hand-over. The sparse and full patterns tell correct wrap-around order apart from fixed priority. Holding frame_n low while requests change shows whether the grant is frozen during a transfer or released when the owner drops its request. In device mode the incoming grant is pulsed while the unused request pins toggle. This separates the one-clock drive delay from a direct pass-through and shows that pins 3..1 are ignored.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

  typedef enum logic {
    MODE_DEVICE = 1'b0,
    MODE_HOST   = 1'b1
  } bus_mode_e;

  // Step one position around a ring of n slots.
  function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/pci_rr_core.sv
module pci_rr_core
  import pci_arb_pkg::*;
#(
  parameter int NM   = 5,
  parameter int IDXW = $clog2(NM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [NM-1:0] req,
  input  logic          bus_idle,
  output logic [NM-1:0] gnt_vec,
  output logic          gap_o,
  output logic          allowed_o
);

  logic [IDXW-1:0] owner_q;
  logic            gap_q;
  logic [IDXW-1:0] target;

  // Scan from owner+1 around the ring; owner itself is last; park on 0.
  function automatic logic [IDXW-1:0] pick_next(logic [NM-1:0] r, logic [IDXW-1:0] cur);
    int unsigned     idx;
    logic [IDXW-1:0] pos;
    logic [IDXW-1:0] res;
    logic            hit;
    idx = 32'(cur);
    res = '0;
    hit = 1'b0;
    for (int k = 0; k < NM; k++) begin
      idx = ring_next(idx, NM);
      pos = IDXW'(idx);
      if (!hit && r[pos]) begin
        res = pos;
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  assign target    = pick_next(req, owner_q);
  assign allowed_o = bus_idle || !req[owner_q];
  assign gap_o     = gap_q;
  assign gnt_vec   = gap_q ? '0 : (NM'(1) << owner_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      gap_q   <= 1'b0;
    end else if (!enable) begin
      owner_q <= '0;
      gap_q   <= 1'b0;
    end else if (gap_q) begin
      gap_q <= 1'b0;
    end else if (allowed_o && (target != owner_q)) begin
      owner_q <= target;
      gap_q   <= 1'b1;
    end
  end

endmodule

// File: rtl/pci_nh_link.sv
module pci_nh_link (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic gnt_in_n,
  output logic granted,
  output logic drive
);

  logic seen_q;
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      seen_q <= enable & ~gnt_in_n;
      held_q <= enable & seen_q;
    end
  end

  assign granted = seen_q;
  assign drive   = seen_q & held_q;

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter
  import pci_arb_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_mode,
  input  logic               int_req,
  input  logic               cfg_req,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [NUM_EXT-1:0] ext_req_n,
  output logic [NUM_EXT-1:0] ext_gnt_n,
  output logic               int_gnt,
  output logic               int_oe,
  output logic               cfg_reject
);

  localparam int NM   = NUM_EXT + 1;
  localparam int IDXW = $clog2(NM);

  logic          is_host;
  logic [NM-1:0] req_vec;
  logic          bus_idle;
  logic [NM-1:0] host_gnt;
  logic          host_gap;
  logic          host_allowed;
  logic          nh_gnt;
  logic          nh_drive;

  assign is_host  = (host_mode == MODE_HOST);
  assign req_vec  = {~ext_req_n, int_req};
  assign bus_idle = frame_n & irdy_n;

  pci_rr_core #(.NM(NM), .IDXW(IDXW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (is_host),
    .req       (req_vec),
    .bus_idle  (bus_idle),
    .gnt_vec   (host_gnt),
    .gap_o     (host_gap),
    .allowed_o (host_allowed)
  );

  pci_nh_link u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (~is_host),
    .gnt_in_n (ext_req_n[0]),
    .granted  (nh_gnt),
    .drive    (nh_drive)
  );

  always_comb begin
    if (is_host) begin
      ext_gnt_n = ~host_gnt[NM-1:1];
      int_gnt   = host_gnt[0];
      int_oe    = host_gnt[0];
    end else begin
      ext_gnt_n    = '1;
      ext_gnt_n[0] = ~int_req;
      int_gnt      = nh_gnt;
      int_oe       = nh_drive;
    end
  end

  assign cfg_reject = cfg_req & ~is_host;

endmodule

// File: rtl/pci_arb_checks.sv
module pci_arb_checks #(
  parameter int NUM_EXT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_mode,
  input logic [NUM_EXT-1:0] ext_gnt_n,
  input logic               int_gnt,
  input logic               int_oe,
  input logic [NUM_EXT:0]   gnt_vec,
  input logic               gap,
  input logic               allowed
);

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |-> ($countones({~ext_gnt_n, int_gnt}) <= 1)); // R1

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && int_oe) |-> (&ext_gnt_n)); // R7

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && $past(host_mode) && (|gnt_vec) && (|$past(gnt_vec)))
      |-> (gnt_vec == $past(gnt_vec))); // R4

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && $past(host_mode) && !$past(allowed) && !$past(gap))
      |-> $stable(gnt_vec)); // R6

  AST_DEVICE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |-> (&ext_gnt_n[NUM_EXT-1:1])); // R8

  AST_DEVICE_DRIVE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !$past(host_mode) && int_oe) |-> $past(int_gnt)); // R9

endmodule

bind pci_park_arbiter pci_arb_checks #(.NUM_EXT(NUM_EXT)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_mode (host_mode),
  .ext_gnt_n (ext_gnt_n),
  .int_gnt   (int_gnt),
  .int_oe    (int_oe),
  .gnt_vec   (host_gnt),
  .gap       (host_gap),
  .allowed   (host_allowed)
);

// File: tb/pci_park_arbiter_bench.sv
module pci_park_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_mode = 1'b1;
  logic       int_req = 1'b0;
  logic       cfg_req = 1'b0;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [3:0] ext_req_n = 4'hF;
  logic [3:0] ext_gnt_n;
  logic       int_gnt;
  logic       int_oe;
  logic       cfg_reject;

  always #2 clk = ~clk;

  pci_park_arbiter u_pci_park_arbiter (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .int_req(int_req),
    .cfg_req(cfg_req), .frame_n(frame_n), .irdy_n(irdy_n),
    .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n), .int_gnt(int_gnt),
    .int_oe(int_oe), .cfg_reject(cfg_reject)
  );

  typedef struct packed {
    logic [3:0] gnt_n;
    logic       ig;
    logic       oe;
    logic       rej;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Reference state, kept in the bench's own terms.
  int m_owner = 0;
  bit m_gap   = 1'b0;
  bit m_seen  = 1'b0;
  bit m_held  = 1'b0;

  task automatic cyc(input bit hm, input bit ir, input bit cf, input bit fr,
                     input bit rdy, input logic [3:0] rq, input string tag);
    exp_t e;
    bit [4:0] r;
    bit [4:0] gv;
    int tgt;
    bit ok;
    @(negedge clk);
    host_mode = hm; int_req = ir; cfg_req = cf; frame_n = fr; irdy_n = rdy; ext_req_n = rq;
    if (hm) begin
      gv      = m_gap ? 5'd0 : (5'd1 << m_owner);
      e.gnt_n = ~gv[4:1];
      e.ig    = gv[0];
      e.oe    = gv[0];
    end else begin
      e.gnt_n = {3'b111, ~ir};
      e.ig    = m_seen;
      e.oe    = m_seen & m_held;
    end
    e.rej = cf & ~hm;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (hm) begin
      m_held = 1'b0;
      m_seen = 1'b0;
      if (m_gap) m_gap = 1'b0;
      else begin
        r   = {~rq, ir};
        tgt = 0;
        ok  = 1'b0;
        for (int j = 1; j <= 5; j++) begin
          if (!ok && r[(m_owner + j) % 5]) begin
            tgt = (m_owner + j) % 5;
            ok  = 1'b1;
          end
        end
        if (((fr && rdy) || !r[m_owner]) && tgt != m_owner) begin
          m_owner = tgt;
          m_gap   = 1'b1;
        end
      end
    end else begin
      m_owner = 0;
      m_gap   = 1'b0;
      m_held  = m_seen;
      m_seen  = ~rq[0];
    end
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Monitor: compares each cycle's outputs before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "ext_gnt_n", int'(ext_gnt_n), int'(e.gnt_n));
        cmp(t, "int_gnt", int'(int_gnt), int'(e.ig));
        cmp(t, "int_oe", int'(int_oe), int'(e.oe));
        cmp(t, "cfg_reject", int'(cfg_reject), int'(e.rej));
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state and idle parking
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 1, 4'hF, "R2 park idle");
    // R3: parked controller starts its own transfer without a gap
    cyc(1, 1, 0, 1, 1, 4'hF, "R3 own start");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 4'hF, "R3 own busy");
    // R4: single off-chip requester takes over after one empty clock
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, 1, 4'b1110, "R4 handover");
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, 0, 4'b1110, "R4 owner busy");
    // R5: sparse requesters (initiators 2 and 4) rotate
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 1, 1, 4'b0101, "R5 sparse rotate");
    // R6: busy bus freezes the grant while the owner still requests
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 4'b0000, "R6 hold busy");
    // R6: owner request gone during a busy bus allows a change
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 4'b1111, "R6 owner drop");
    // R5 R1 R7: everyone requests, idle bus
    for (int i = 0; i < 12; i++) cyc(1, 1, 0, 1, 1, 4'b0000, "R5 full rotate");
    // R2: return to park with a gap
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 1, 4'hF, "R2 repark");
    // R10: host mode does not refuse
    cyc(1, 0, 1, 1, 1, 4'hF, "R10 host cfg");
    // R8 R9: device mode
    cyc(0, 1, 0, 1, 1, 4'hF, "R8 req out");
    cyc(0, 1, 0, 1, 1, 4'b0001, "R8 ignore upper pins");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 1, 4'b1010, "R9 grant in");
    cyc(0, 0, 0, 1, 1, 4'b0101, "R9 grant gone");
    cyc(0, 0, 0, 1, 1, 4'b1110, "R9 grant pulse");
    cyc(0, 0, 0, 1, 1, 4'b1111, "R9 pulse end");
    cyc(0, 0, 1, 1, 1, 4'b1111, "R10 device cfg");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 4'b0001, "R8 upper toggle");
    // R2: back to host, parked again
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 1, 4'hF, "R2 host again");
    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule